// File: doc/BRIEF.md
# Unlock-Protected Byte Memory Write Controller

This block sits on a simple register bus in front of a small byte-wide nonvolatile data store, kept here as an internal array. Software loads a two-part byte pointer and a data latch, sets a write-enable bit, and then asks for a write. Before a write is allowed, a key register has to receive two fixed values as two back-to-back bus writes. Any write that comes without this unlock sequence, or that arrives in the wrong order, is refused.

Once a request is accepted, the controller waits a fixed lead-in of clock edges. It then runs a timed programming phase that replaces the whole target byte (erase followed by write). At the end it clears the start bit by itself, gives a one-cycle done pulse and sets a sticky interrupt flag. Software can poll the start bit, or wait for the interrupt. A separate read selector returns the stored byte at the current pointer.

Bus encoding: `busSel` 0 is the low pointer byte, 1 the high pointer bits, 2 the data latch, 3 the control register, 4 the key register (reads as 0), and 5 a read-only view of the array byte at the pointer. Control register bits: 7 memory select, 6 config select, 4 interrupt flag (write 1 to clear), 3 error flag (write 1 to clear), 2 write enable, 1 start. Bits 5 and 0 read as 0.

Top module: `eeWriteCtl`

## Requirements
- R1: A synchronous active-high `rst` clears the pointer, the latch, all control bits and the unlock state. After reset every register reads 0 and `donePulse` and `irqOut` are 0.
- R2: Writes to selectors 0, 1 and 2 load the low pointer, the high pointer and the latch, and the same selectors read them back. The high pointer keeps only its low ADDR_W-8 bits.
- R3: A start is accepted when all of the following hold: the key register has just received 55h and then AAh as the two bus writes immediately before; write enable (bit 2) was already 1; and the control write sets bit 1 with bits 7:6 both 0. After an accepted start, bit 1 reads 1. Exactly START_DELAY+WRITE_CYCLES clock edges later, the array byte at the captured pointer equals the captured latch, replacing every bit.
- R4: On the edge that stores the byte, bit 1 returns to 0. `donePulse` is high for exactly that one cycle, and the interrupt flag (bit 4, `irqOut`) is set.
- R5: A wrong key value, or any other bus write between 55h and AAh or between AAh and the control write, cancels the unlock, and the next start is refused.
- R6: Write enable set in the same control write as the start bit does not qualify. The start is refused.
- R7: A start with bit 7 or bit 6 set is refused and leaves the array unchanged.
- R8: A refused start leaves bit 1 at 0 and sets the sticky error flag (bit 3). Writing 1 to bit 3 or to bit 4 clears that flag.
- R9: The unlock is used up by one start request, whether it is accepted or refused. A second start needs a new 55h/AAh pair.
- R10: While a write is in progress, bus writes to the pointer, latch and control registers are ignored. Selector 5 keeps returning the old byte until the store edge.
- R11: A reset during a write aborts it. The array is left unchanged and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWe | input | 1 | Bus write strobe, one write per cycle |
| busSel | input | 3 | Register selector |
| busWData | input | 8 | Bus write data |
| busRData | output | 8 | Read data for the selected register |
| donePulse | output | 1 | One-cycle pulse when a write completes |
| irqOut | output | 1 | Sticky interrupt flag, mirrors control bit 4 |

## Verification
The bench builds the block with ADDR_W=9, START_DELAY=4 and WRITE_CYCLES=5. This gives a 512-byte array with one high-pointer bit, which brings the high-pointer masking and a full nine-bit address within reach. The short programming window means every accepted write finishes in nine edges, so the run can cover rejected unlocks, blocked writes during a busy window, a reset in the middle of a write and back-to-back requests in a few hundred cycles. A behavioural model follows the bus on every clock and checks the read data, the done pulse and the interrupt output at each cycle.

// File: rtl/eeWritePkg.sv
package eeWritePkg;

  // Register selector codes
  localparam logic [2:0] SEL_PTR_LO = 3'd0;
  localparam logic [2:0] SEL_PTR_HI = 3'd1;
  localparam logic [2:0] SEL_LATCH  = 3'd2;
  localparam logic [2:0] SEL_CTRL   = 3'd3;
  localparam logic [2:0] SEL_KEY    = 3'd4;
  localparam logic [2:0] SEL_ARRAY  = 3'd5;

  // Control register bit positions
  localparam int CB_MEMSEL = 7;
  localparam int CB_CFGSEL = 6;
  localparam int CB_IRQ    = 4;
  localparam int CB_ERR    = 3;
  localparam int CB_WREN   = 2;
  localparam int CB_START  = 1;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_ARMED} unlock_e;
  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_PROG} phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldPtrLo;
    logic ldPtrHi;
    logic ldLatch;
    logic ldCtrl;
    logic clrErr;
    logic clrIrq;
    logic setErr;
    logic capture;
    logic commit;
  } dpStrobe_t;

endpackage

// File: rtl/eeUnlockTrack.sv
module eeUnlockTrack
  import eeWritePkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busWe,
  input  logic       keyWr,
  input  logic [7:0] wData,
  output logic       armed
);

  unlock_e state, stateNext;

  always_comb begin
    stateNext = state;
    if (busWe) begin
      if (keyWr && wData == KEY_FIRST)
        stateNext = UL_HALF;
      else if (keyWr && wData == KEY_SECOND && state == UL_HALF)
        stateNext = UL_ARMED;
      else
        stateNext = UL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= UL_IDLE;
    else     state <= stateNext;
  end

  assign armed = (state == UL_ARMED);

endmodule

// File: rtl/eeCtlUnit.sv
module eeCtlUnit
  import eeWritePkg::*;
#(
  parameter int START_DELAY  = 4,
  parameter int WRITE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busWe,
  input  logic [2:0] busSel,
  input  logic [7:0] busWData,
  input  logic       wrEnOld,
  output dpStrobe_t  strobe,
  output logic       startBit,
  output logic       keyArmed,
  output logic       donePulse
);

  localparam int MAXC  = (START_DELAY > WRITE_CYCLES) ? START_DELAY : WRITE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(START_DELAY - 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(WRITE_CYCLES - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             doneQ;
  logic             busy, wrOpen, ctrlWr, startReq, accept;

  eeUnlockTrack u_unlock (
    .clk   (clk),
    .rst   (rst),
    .busWe (busWe),
    .keyWr (busSel == SEL_KEY),
    .wData (busWData),
    .armed (keyArmed)
  );

  always_comb begin
    busy     = (phase != PH_IDLE);
    wrOpen   = busWe && !busy;
    ctrlWr   = wrOpen && (busSel == SEL_CTRL);
    startReq = ctrlWr && busWData[CB_START];
    accept   = startReq && keyArmed && wrEnOld &&
               (busWData[CB_MEMSEL:CB_CFGSEL] == 2'b00);

    strobe.ldPtrLo = wrOpen && (busSel == SEL_PTR_LO);
    strobe.ldPtrHi = wrOpen && (busSel == SEL_PTR_HI);
    strobe.ldLatch = wrOpen && (busSel == SEL_LATCH);
    strobe.ldCtrl  = ctrlWr;
    strobe.clrErr  = ctrlWr && busWData[CB_ERR];
    strobe.clrIrq  = ctrlWr && busWData[CB_IRQ];
    strobe.setErr  = startReq && !accept;
    strobe.capture = accept;
    strobe.commit  = (phase == PH_PROG) && (cnt == PROG_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase <= PH_LEAD;
            cnt   <= '0;
          end
        end
        PH_LEAD: begin
          if (cnt == LEAD_LAST) begin
            phase <= PH_PROG;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_PROG: begin
          if (cnt == PROG_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            doneQ <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign startBit  = busy;
  assign donePulse = doneQ;

endmodule

// File: rtl/eeDataPath.sv
module eeDataPath
  import eeWritePkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  dpStrobe_t  strobe,
  input  logic [2:0] busSel,
  input  logic [7:0] busWData,
  input  logic       startBit,
  output logic [7:0] busRData,
  output logic       wrEnOld,
  output logic       irqOut,
  output logic       errView,
  output logic [7:0] ptrLoView,
  output logic [7:0] latchView
);

  localparam int HI_W  = ADDR_W - 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        ptrLoQ, latchQ, tgtData;
  logic [HI_W-1:0]   ptrHiQ;
  logic [ADDR_W-1:0] tgtAddr, ptrFull;
  logic              memSelQ, cfgSelQ, wrEnQ, errQ, irqQ;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        ctrlView, arrayByte;

  // Erased state of the nonvolatile store
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptrLoQ  <= '0;
      ptrHiQ  <= '0;
      latchQ  <= '0;
      memSelQ <= 1'b0;
      cfgSelQ <= 1'b0;
      wrEnQ   <= 1'b0;
      errQ    <= 1'b0;
      irqQ    <= 1'b0;
      tgtAddr <= '0;
      tgtData <= '0;
    end else begin
      if (strobe.ldPtrLo) ptrLoQ <= busWData;
      if (strobe.ldPtrHi) ptrHiQ <= busWData[HI_W-1:0];
      if (strobe.ldLatch) latchQ <= busWData;
      if (strobe.ldCtrl) begin
        memSelQ <= busWData[CB_MEMSEL];
        cfgSelQ <= busWData[CB_CFGSEL];
        wrEnQ   <= busWData[CB_WREN];
      end
      if (strobe.setErr)      errQ <= 1'b1;
      else if (strobe.clrErr) errQ <= 1'b0;
      if (strobe.commit)      irqQ <= 1'b1;
      else if (strobe.clrIrq) irqQ <= 1'b0;
      if (strobe.capture) begin
        tgtAddr <= ptrFull;
        tgtData <= latchQ;
      end
    end
  end

  // Whole-byte replacement: erase and program collapse into one store
  always_ff @(posedge clk) begin
    if (!rst && strobe.commit) mem[tgtAddr] <= tgtData;
  end

  always_comb begin
    ptrFull   = {ptrHiQ, ptrLoQ};
    arrayByte = mem[ptrFull];
    ctrlView  = {memSelQ, cfgSelQ, 1'b0, irqQ, errQ, wrEnQ, startBit, 1'b0};
    case (busSel)
      SEL_PTR_LO: busRData = ptrLoQ;
      SEL_PTR_HI: busRData = 8'(ptrHiQ);
      SEL_LATCH:  busRData = latchQ;
      SEL_CTRL:   busRData = ctrlView;
      SEL_ARRAY:  busRData = arrayByte;
      default:    busRData = 8'h00;
    endcase
  end

  assign wrEnOld   = wrEnQ;
  assign irqOut    = irqQ;
  assign errView   = errQ;
  assign ptrLoView = ptrLoQ;
  assign latchView = latchQ;

endmodule

// File: rtl/eeWriteCtl.sv
module eeWriteCtl
  import eeWritePkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int START_DELAY  = 4,
  parameter int WRITE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busWe,
  input  logic [2:0] busSel,
  input  logic [7:0] busWData,
  output logic [7:0] busRData,
  output logic       donePulse,
  output logic       irqOut
);

  dpStrobe_t  strobe;
  logic       startBit, keyArmed, wrEnOld, errFlag;
  logic [7:0] ptrLoView, latchView;

  eeCtlUnit #(
    .START_DELAY  (START_DELAY),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .busWe     (busWe),
    .busSel    (busSel),
    .busWData  (busWData),
    .wrEnOld   (wrEnOld),
    .strobe    (strobe),
    .startBit  (startBit),
    .keyArmed  (keyArmed),
    .donePulse (donePulse)
  );

  eeDataPath #(
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .busSel    (busSel),
    .busWData  (busWData),
    .startBit  (startBit),
    .busRData  (busRData),
    .wrEnOld   (wrEnOld),
    .irqOut    (irqOut),
    .errView   (errFlag),
    .ptrLoView (ptrLoView),
    .latchView (latchView)
  );

endmodule

// File: rtl/eeWriteCtl_chk.sv
module eeWriteCtl_chk (
  input logic       clk,
  input logic       rst,
  input logic       donePulse,
  input logic       irqOut,
  input logic       startBit,
  input logic       errFlag,
  input logic       keyArmed,
  input logic [7:0] ptrLo,
  input logic [7:0] latch
);

  // R3: a start can only rise out of an armed unlock
  p_start_needs_key_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(startBit) |-> $past(keyArmed));

  // R4: done lasts one cycle
  p_done_onecycle_r4: assert property (@(posedge clk) disable iff (rst)
    donePulse |=> !donePulse);

  // R4: done comes with the interrupt flag
  p_done_irq_r4: assert property (@(posedge clk) disable iff (rst)
    donePulse |-> irqOut);

  // R4: start clearing outside reset means completion
  p_done_clears_start_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(startBit)) |-> donePulse);

  // R8: a rising error flag leaves start low
  p_reject_no_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(errFlag) |-> !startBit);

  // R10: pointer and latch hold while busy
  p_hold_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (startBit && $past(startBit)) |-> ($stable(ptrLo) && $stable(latch)));

endmodule

bind eeWriteCtl eeWriteCtl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .donePulse (donePulse),
  .irqOut    (irqOut),
  .startBit  (startBit),
  .errFlag   (errFlag),
  .keyArmed  (keyArmed),
  .ptrLo     (ptrLoView),
  .latch     (latchView)
);

// File: tb/eeWriteCtl_tb.sv
`timescale 1ns/1ps
module eeWriteCtl_tb;

  localparam int ADDR_W = 9;
  localparam int SD     = 4;
  localparam int WC     = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_MSK = (1 << (ADDR_W - 8)) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busWe = 1'b0;
  logic [2:0] busSel = 3'd0;
  logic [7:0] busWData = 8'd0;
  logic [7:0] busRData;
  logic       donePulse, irqOut;

  int errors = 0;
  int checks = 0;
  int doneCnt = 0;
  bit cmpOn = 0;
  bit finished = 0;

  // Behavioural reference state
  int mPtrLo = 0, mPtrHi = 0, mLatch = 0;
  int mMem7 = 0, mCfg = 0, mWren = 0, mErr = 0, mIrq = 0, mStart = 0;
  int mCount = 0, mUlk = 0, mDone = 0, mAddr = 0, mData = 0;
  int mMem [DEPTH];

  always #2 clk = ~clk;

  eeWriteCtl #(.ADDR_W(ADDR_W), .START_DELAY(SD), .WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rst(rst), .busWe(busWe), .busSel(busSel), .busWData(busWData),
    .busRData(busRData), .donePulse(donePulse), .irqOut(irqOut)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int modelRead(int sel);
    case (sel)
      0: return mPtrLo;
      1: return mPtrHi;
      2: return mLatch;
      3: return mMem7*128 + mCfg*64 + mIrq*16 + mErr*8 + mWren*4 + mStart*2;
      5: return mMem[mPtrHi*256 + mPtrLo];
      default: return 0;
    endcase
  endfunction

  initial for (int i = 0; i < DEPTH; i++) mMem[i] = 8'hFF;

  always @(posedge clk) begin
    int wd, busy, armed, accept;
    wd = busWData;
    if (rst) begin
      mPtrLo = 0; mPtrHi = 0; mLatch = 0; mMem7 = 0; mCfg = 0; mWren = 0;
      mErr = 0; mIrq = 0; mStart = 0; mCount = 0; mUlk = 0; mDone = 0;
      cmpOn = 1;
    end else begin
      busy = (mCount > 0);
      armed = (mUlk == 2);
      mDone = 0;
      if (busWe) begin
        if (!busy) begin
          case (busSel)
            0: mPtrLo = wd;
            1: mPtrHi = wd & HI_MSK;
            2: mLatch = wd;
            3: begin
              accept = armed && mWren == 1 && ((wd >> 6) & 3) == 0;
              mMem7 = (wd >> 7) & 1;
              mCfg  = (wd >> 6) & 1;
              mWren = (wd >> 2) & 1;
              if ((wd >> 3) & 1) mErr = 0;
              if ((wd >> 4) & 1) mIrq = 0;
              if ((wd >> 1) & 1) begin
                if (accept) begin
                  mStart = 1; mCount = SD + WC;
                  mAddr = mPtrHi*256 + mPtrLo; mData = mLatch;
                end else mErr = 1;
              end
            end
            default: ;
          endcase
        end
        if (busSel == 4 && wd == 8'h55) mUlk = 1;
        else if (busSel == 4 && wd == 8'hAA && mUlk == 1) mUlk = 2;
        else mUlk = 0;
      end
      if (busy) begin
        mCount--;
        if (mCount == 0) begin
          mMem[mAddr] = mData; mStart = 0; mDone = 1; mIrq = 1;
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R4 done", int'(donePulse), mDone);
      chk("R4 irq", int'(irqOut), mIrq);
      chk(busSel == 5 ? "R3 array" : (busSel == 3 ? "R8 ctrl" : "R2 reg"),
          int'(busRData), modelRead(busSel));
    end
    if (donePulse) doneCnt++;
  end

  task automatic wr(int sel, int d);
    busWe = 1'b1; busSel = 3'(sel); busWData = 8'(d);
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic rd(int sel, output int v);
    busSel = 3'(sel); #0.5;
    v = busRData;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic unlock();
    wr(4, 8'h55); wr(4, 8'hAA);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int v;
    idle(2);
    rst = 1'b0;

    // R1 reset state
    rd(3, v); chk("R1 ctrl", v, 0);
    rd(0, v); chk("R1 ptrLo", v, 0);
    rd(2, v); chk("R1 latch", v, 0);
    chk("R1 irqOut", int'(irqOut), 0);

    // R2 register load and readback, high pointer masking
    wr(0, 8'h34); wr(1, 8'hFF); wr(2, 8'h5A);
    rd(0, v); chk("R2 ptrLo", v, 8'h34);
    rd(1, v); chk("R2 ptrHi masked", v, 8'h01);
    rd(2, v); chk("R2 latch", v, 8'h5A);
    rd(5, v); chk("R3 erased before write", v, 8'hFF);

    // R3 accepted write, R10 blocked writes while busy
    wr(3, 8'h04); unlock(); wr(3, 8'h06);
    rd(3, v); chk("R3 start visible", v, 8'h06);
    wr(2, 8'h11);
    rd(2, v); chk("R10 latch blocked", v, 8'h5A);
    rd(5, v); chk("R10 old byte", v, 8'hFF);
    idle(SD + WC + 1);
    rd(5, v); chk("R3 stored byte", v, 8'h5A);
    rd(3, v); chk("R4 start cleared irq set", v, 8'h14);
    chk("R4 one done", doneCnt, 1);

    // R8 write-1-to-clear irq
    wr(3, 8'h14);
    rd(3, v); chk("R8 irq cleared", v, 8'h04);

    // R5 wrong second key
    wr(4, 8'h55); wr(4, 8'h12); wr(3, 8'h06);
    rd(3, v); chk("R5 wrong key refused", v, 8'h0C);
    wr(3, 8'h0C);
    rd(3, v); chk("R8 err cleared", v, 8'h04);

    // R5 intervening write
    wr(4, 8'h55); wr(2, 8'h77); wr(4, 8'hAA); wr(3, 8'h06);
    rd(3, v); chk("R5 intervening refused", v, 8'h0C);
    wr(3, 8'h0C);

    // R6 enable in same access
    wr(3, 8'h00); unlock(); wr(3, 8'h06);
    rd(3, v); chk("R6 late enable refused", v, 8'h0C);
    wr(3, 8'h0C);

    // R7 memory select set
    unlock(); wr(3, 8'h86);
    rd(3, v); chk("R7 select refused", v, 8'h8C);
    idle(SD + WC + 2);
    rd(5, v); chk("R7 array untouched", v, 8'h5A);
    chk("R7 no done", doneCnt, 1);
    wr(3, 8'h0C);

    // R9 single-use unlock
    unlock(); wr(3, 8'h06);
    idle(SD + WC + 1);
    rd(5, v); chk("R3 full replacement", v, 8'h77);
    wr(3, 8'h06);
    rd(3, v); chk("R9 reuse refused", v, 8'h1C);
    wr(3, 8'h1C);
    rd(3, v); chk("R8 both cleared", v, 8'h04);

    // R11 reset mid-write
    wr(0, 8'h10); wr(2, 8'hC3); unlock(); wr(3, 8'h06);
    idle(3);
    rst = 1'b1; idle(1); rst = 1'b0;
    rd(3, v); chk("R11 ctrl after abort", v, 0);
    idle(SD + WC + 2);
    chk("R11 no done", doneCnt, 2);
    wr(0, 8'h10); wr(1, 8'h01);
    rd(5, v); chk("R11 array unchanged", v, 8'hFF);

    idle(2);
    summary();
  end

endmodule